// File: doc/BRIEF.md
# Dual-Port Word Store with Single-Correct / Double-Detect Protection

This block is a true dual-port memory for 8-bit words. The storage array has no error protection of its own. Each port therefore has its own protection logic. On the write side, a registered encoder turns each 8-bit word into a 13-bit codeword before it is stored. On the read side, a registered decoder corrects any single flipped bit and flags words that cannot be corrected. For each read, the decoder also reports a two-bit verdict.

Port A has one extra test input. It inverts the lowest bit of the codeword just before that codeword is written. This lets a system plant a known fault and watch the read path deal with it.

Each port has one address. That address is used for the read issued in the same cycle and for the write issued in the same cycle. A write lands in the array on the second clock edge after it is issued. Read results appear on the second edge after the read is issued.

Top module: `ecc_dpram`

## Requirements
- R1: Codeword layout. Bit 0 is the overall even parity over bits 12..1. Bits 12..1 are Hamming positions 12..1. Check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. A word written on either port and read back on either port returns the same data with status 00.
- R2: A read issued in cycle k (port read enable high) shows its data and status on the port outputs after the clock edge that ends cycle k+1.
- R3: A write issued in cycle k is visible to reads issued in cycle k+2 or later. A read of the same address issued in cycle k+1 returns the previous contents.
- R4: The two ports write different addresses in the same cycle without disturbing each other. Each port can read what the other wrote.
- R5: When both ports write the same address in the same cycle, port A's data is kept.
- R6: A write on port A with the inject input high stores the codeword with bit 0 inverted. A later read on either port returns the original data with status 01.
- R7: Status encoding is 00 for a clean word, 01 for a corrected single-bit error and 10 for an uncorrectable error. The value 11 never appears.
- R8: A codeword with exactly two flipped bits is decoded with status 10. Its data output carries the raw, uncorrected data positions of the received codeword.
- R9: A codeword with any one of its 13 bits flipped is decoded to the original data with status 01.
- R10: After reset, both read data outputs are 0 and both statuses are 00.
- R11: While a port issues no reads, its read data and status outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| a_addr | input | 4 | Port A word address (read and write) |
| a_wdata | input | 8 | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_inject | input | 1 | Port A: invert codeword bit 0 of this write |
| a_rdata | output | 8 | Port A corrected read data |
| a_status | output | 2 | Port A decode status |
| b_addr | input | 4 | Port B word address (read and write) |
| b_wdata | input | 8 | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_rdata | output | 8 | Port B corrected read data |
| b_status | output | 2 | Port B decode status |

## Verification
Two events can fall on the same clock edge: a delayed write landing in the array, and a read sampling that same location. Both ports' writes can also land on one address at once. The bench provokes these cases directly, with a read of the written address one cycle after the write and with same-address writes from both ports. Random traffic over only sixteen addresses produces many more such collisions. A bench model commits each write two cycles after it is issued and resolves same-address pairs in port A's favour. Every read result is judged against that model, so old-data returns and port A priority are checked cycle by cycle.

// File: rtl/ecc_dpram_pkg.sv
package ecc_dpram_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CW_W   = DATA_W + CHK_W + 1;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CW_W-1:0] cw_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int              idx;
        logic            par;
        cw  = '0;
        idx = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[idx];
                idx++;
            end
        end
        for (int j = 0; j < CHK_W; j++) begin
            par = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (p[j]) par ^= cw[p];
            end
            cw[1 << j] = par;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] cw_extract(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int                idx;
        d   = '0;
        idx = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[idx] = cw[p];
                idx++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ecc_wr_stage.sv
module ecc_wr_stage
    import ecc_dpram_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter bit INJECT_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inject,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [CW_W-1:0]   st_cw
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [CW_W-1:0]   cw;
        logic              flip;
    } wr_t;

    wr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.we   = we;
        st_d.addr = addr;
        st_d.cw   = cw_encode(wdata);
        st_d.flip = INJECT_EN ? (inject & we) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_we   = st_q.we;
    assign st_addr = st_q.addr;
    assign st_cw   = {st_q.cw[CW_W-1:1], st_q.cw[0] ^ st_q.flip};

    AST_INJECT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> ((^st_cw) == st_q.flip)) else $error("inject parity"); // R6

endmodule

// File: rtl/ecc_store.sv
module ecc_store
    import ecc_dpram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [CW_W-1:0]   a_wcw,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [CW_W-1:0]   b_wcw,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_raddr,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [CW_W-1:0]   a_rcw,
    output logic [CW_W-1:0]   b_rcw
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [CW_W-1:0] a;
        logic [CW_W-1:0] b;
    } rd_t;

    logic [CW_W-1:0] mem_q [DEPTH];
    rd_t             rd_d, rd_q;

    // Port B first so that port A's assignment wins on a shared address.
    always_ff @(posedge clk) begin
        if (b_we) mem_q[b_waddr] <= b_wcw;
        if (a_we) mem_q[a_waddr] <= a_wcw;
    end

    always_comb begin
        rd_d = rd_q;
        if (a_re) rd_d.a = mem_q[a_raddr];
        if (b_re) rd_d.b = mem_q[b_raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign a_rcw = rd_q.a;
    assign b_rcw = rd_q.b;

    AST_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && (a_waddr == b_waddr)) |=> (mem_q[$past(a_waddr)] == $past(a_wcw)))
        else $error("port A priority"); // R5

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_dpram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic [1:0]        status
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [1:0]        status;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        logic [CHK_W-1:0] syn;
        logic             par;
        logic [CW_W-1:0]  fixed;
        ecc_status_e      st;
        syn   = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn ^= CHK_W'(p);
        end
        par   = ^cw;
        fixed = cw;
        st    = ST_CLEAN;
        if (par) begin
            if (syn == '0) begin
                fixed[0] = ~cw[0];
                st       = ST_FIXED;
            end else if (syn <= CHK_W'(CW_W - 1)) begin
                fixed[syn] = ~cw[syn];
                st         = ST_FIXED;
            end else begin
                st = ST_FATAL;
            end
        end else if (syn != '0) begin
            st = ST_FATAL;
        end
        dec_d        = dec_q;
        dec_d.data   = cw_extract(fixed);
        dec_d.status = st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign data   = dec_q.data;
    assign status = dec_q.status;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11) else $error("illegal status"); // R7
    AST_CLEAN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cw == cw_encode(cw_extract(cw))) |=> (status == ST_CLEAN)) else $error("clean word flagged"); // R1

endmodule

// File: rtl/ecc_dpram.sv
module ecc_dpram
    import ecc_dpram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    input  logic              a_inject,
    output logic [DATA_W-1:0] a_rdata,
    output logic [1:0]        a_status,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        b_status
);

    logic              a_st_we, b_st_we;
    logic [ADDR_W-1:0] a_st_addr, b_st_addr;
    logic [CW_W-1:0]   a_st_cw, b_st_cw;
    logic [CW_W-1:0]   a_rcw, b_rcw;

    ecc_wr_stage #(.ADDR_W(ADDR_W), .INJECT_EN(1'b1)) u_wr_a (
        .clk(clk), .rst_n(rst_n), .we(a_we), .addr(a_addr), .wdata(a_wdata),
        .inject(a_inject), .st_we(a_st_we), .st_addr(a_st_addr), .st_cw(a_st_cw)
    );

    ecc_wr_stage #(.ADDR_W(ADDR_W), .INJECT_EN(1'b0)) u_wr_b (
        .clk(clk), .rst_n(rst_n), .we(b_we), .addr(b_addr), .wdata(b_wdata),
        .inject(1'b0), .st_we(b_st_we), .st_addr(b_st_addr), .st_cw(b_st_cw)
    );

    ecc_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_st_we), .a_waddr(a_st_addr), .a_wcw(a_st_cw),
        .b_we(b_st_we), .b_waddr(b_st_addr), .b_wcw(b_st_cw),
        .a_re(a_re), .a_raddr(a_addr), .b_re(b_re), .b_raddr(b_addr),
        .a_rcw(a_rcw), .b_rcw(b_rcw)
    );

    ecc_dec u_dec_a (.clk(clk), .rst_n(rst_n), .cw(a_rcw), .data(a_rdata), .status(a_status));
    ecc_dec u_dec_b (.clk(clk), .rst_n(rst_n), .cw(b_rcw), .data(b_rdata), .status(b_status));

    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(a_re) && !$past(a_re, 2)) |-> ($stable(a_rdata) && $stable(a_status)))
        else $error("port A hold"); // R11
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(b_re) && !$past(b_re, 2)) |-> ($stable(b_rdata) && $stable(b_status)))
        else $error("port B hold"); // R11

endmodule

// File: tb/ecc_dpram_tb_top.sv
module ecc_dpram_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_addr = '0, b_addr = '0;
    logic [7:0] a_wdata = '0, b_wdata = '0;
    logic       a_we = 1'b0, a_re = 1'b0, a_inject = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic [7:0] a_rdata, b_rdata;
    logic [1:0] a_status, b_status;
    logic [12:0] u_cw = '0;
    logic [7:0]  u_data;
    logic [1:0]  u_status;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ecc_dpram dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_inject(a_inject),
        .a_rdata(a_rdata), .a_status(a_status),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .b_rdata(b_rdata), .b_status(b_status)
    );

    ecc_dec u_dec (.clk(clk), .rst_n(rst_n), .cw(u_cw), .data(u_data), .status(u_status));

    function automatic bit pw2(int p);
        return (p == 1) || (p == 2) || (p == 4) || (p == 8);
    endfunction

    function automatic logic [12:0] m_enc(logic [7:0] d);
        logic [12:0] c = '0;
        int k = 0;
        for (int p = 1; p <= 12; p++) if (!pw2(p)) begin c[p] = d[k]; k++; end
        for (int j = 0; j < 4; j++) begin
            logic x = 1'b0;
            for (int p = 1; p <= 12; p++) if ((p >> j) & 1) x ^= c[p];
            c[1 << j] = x;
        end
        c[0] = ^c[12:1];
        return c;
    endfunction

    function automatic logic [7:0] m_raw(logic [12:0] c);
        logic [7:0] d = '0;
        int k = 0;
        for (int p = 1; p <= 12; p++) if (!pw2(p)) begin d[k] = c[p]; k++; end
        return d;
    endfunction

    function automatic logic [9:0] m_dec(logic [12:0] c);
        int s = 0;
        for (int p = 1; p <= 12; p++) if (c[p]) s ^= p;
        if (^c) begin
            if (s == 0)       return {m_raw(c), 2'b01};
            else if (s <= 12) begin c[s] = ~c[s]; return {m_raw(c), 2'b01}; end
            else              return {m_raw(c), 2'b10};
        end
        if (s != 0) return {m_raw(c), 2'b10};
        return {m_raw(c), 2'b00};
    endfunction

    task automatic chk(bit ok, string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual data=%h st=%b expected data=%h st=%b",
                     tag, act[9:2], act[1:0], exp[9:2], exp[1:0]);
        end
    endtask

    // Bench model: index 0 = issued last iteration, 1 = two iterations ago.
    logic [12:0] mdl [16];
    bit          wa_v[2], wb_v[2], ra_v[2], rb_v[2];
    logic [3:0]  wa_ad[2], wb_ad[2];
    logic [12:0] wa_cw[2], wb_cw[2];
    logic [9:0]  ra_e[2], rb_e[2], last_a, last_b;
    string       ra_t[2], rb_t[2];
    bit          have_a = 0, have_b = 0;

    task automatic cyc(bit awe, bit are, bit ainj, logic [3:0] aad, logic [7:0] awd,
                       bit bwe, bit bre, logic [3:0] bad, logic [7:0] bwd, string tag);
        @(negedge clk);
        if (ra_v[1]) begin
            chk({a_rdata, a_status} === ra_e[1], {ra_t[1], " portA"}, {a_rdata, a_status}, ra_e[1]);
            last_a = ra_e[1]; have_a = 1;
        end else if (have_a)
            chk({a_rdata, a_status} === last_a, "R11 portA hold", {a_rdata, a_status}, last_a);
        if (rb_v[1]) begin
            chk({b_rdata, b_status} === rb_e[1], {rb_t[1], " portB"}, {b_rdata, b_status}, rb_e[1]);
            last_b = rb_e[1]; have_b = 1;
        end else if (have_b)
            chk({b_rdata, b_status} === last_b, "R11 portB hold", {b_rdata, b_status}, last_b);
        if (wb_v[1]) mdl[wb_ad[1]] = wb_cw[1];
        if (wa_v[1]) mdl[wa_ad[1]] = wa_cw[1];   // R5: A lands last
        wa_v[1] = wa_v[0]; wa_ad[1] = wa_ad[0]; wa_cw[1] = wa_cw[0];
        wb_v[1] = wb_v[0]; wb_ad[1] = wb_ad[0]; wb_cw[1] = wb_cw[0];
        ra_v[1] = ra_v[0]; ra_e[1] = ra_e[0]; ra_t[1] = ra_t[0];
        rb_v[1] = rb_v[0]; rb_e[1] = rb_e[0]; rb_t[1] = rb_t[0];
        wa_v[0] = awe; wa_ad[0] = aad; wa_cw[0] = m_enc(awd) ^ {12'd0, ainj};
        wb_v[0] = bwe; wb_ad[0] = bad; wb_cw[0] = m_enc(bwd);
        ra_v[0] = are; ra_e[0] = m_dec(mdl[aad]); ra_t[0] = tag;
        rb_v[0] = bre; rb_e[0] = m_dec(mdl[bad]); rb_t[0] = tag;
        a_we = awe; a_re = are; a_inject = ainj; a_addr = aad; a_wdata = awd;
        b_we = bwe; b_re = bre; b_addr = bad; b_wdata = bwd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    endtask

    task automatic dec_try(logic [12:0] c, logic [9:0] exp, string tag);
        @(negedge clk);
        u_cw = c;
        @(negedge clk);
        chk({u_data, u_status} === exp, tag, {u_data, u_status}, exp);
    endtask

    initial begin
        void'($urandom(32'h5EC0DE));
        for (int i = 0; i < 2; i++) begin
            wa_v[i] = 0; wb_v[i] = 0; ra_v[i] = 0; rb_v[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk({a_rdata, a_status, b_rdata, b_status} === '0, "R10 reset",
            {a_rdata, a_status}, 10'd0);
        chk({b_rdata, b_status} === '0, "R10 reset portB", {b_rdata, b_status}, 10'd0);
        rst_n = 1'b1;

        for (int k = 0; k < 8; k++)
            cyc(1, 0, 0, 4'(k), 8'(k * 17 + 3), 1, 0, 4'(k + 8), 8'(k * 29 + 5), "R1");
        idle(2);
        for (int k = 0; k < 8; k++)
            cyc(0, 1, 0, 4'(k + 8), 0, 0, 1, 4'(k), 0, "R1 R2");
        idle(3);

        cyc(1, 0, 0, 4'd5, 8'h3C, 0, 0, 0, 0, "R3");
        cyc(0, 1, 0, 4'd5, 0, 0, 1, 4'd5, 0, "R3 old");
        cyc(0, 1, 0, 4'd5, 0, 0, 1, 4'd5, 0, "R3 new");
        idle(3);

        cyc(1, 0, 0, 4'd1, 8'hA5, 1, 0, 4'd2, 8'h5A, "R4");
        idle(1);
        cyc(0, 1, 0, 4'd2, 0, 0, 1, 4'd1, 0, "R4");
        idle(3);

        cyc(1, 0, 0, 4'd7, 8'hC3, 1, 0, 4'd7, 8'h18, "R5");
        idle(1);
        cyc(0, 1, 0, 4'd7, 0, 0, 1, 4'd7, 0, "R5");
        idle(3);

        cyc(1, 0, 1, 4'd9, 8'h96, 0, 0, 0, 0, "R6");
        idle(1);
        cyc(0, 1, 0, 4'd9, 0, 0, 1, 4'd9, 0, "R6 R7");
        idle(4);

        for (int i = 0; i < 3000; i++)
            cyc($urandom % 2, $urandom % 2, ($urandom % 8) == 0, 4'($urandom), 8'($urandom),
                $urandom % 2, $urandom % 2, 4'($urandom), 8'($urandom), "R2 R3 random");
        idle(3);

        for (int t = 0; t < 20; t++) begin
            logic [7:0]  d = 8'($urandom);
            logic [12:0] c = m_enc(d);
            dec_try(c, {d, 2'b00}, "R1 unit clean");
            for (int b = 0; b < 13; b++)
                dec_try(c ^ (13'd1 << b), {d, 2'b01}, "R9 single flip");
            for (int b = 0; b < 12; b++) begin
                logic [12:0] e = c ^ (13'd1 << b) ^ (13'd1 << (b + 1));
                dec_try(e, {m_raw(e), 2'b10}, "R8 double flip");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule